// File: doc/BRIEF.md
# Reconfigurable Router Input Port

This block is one input port of a mesh router. It carries two virtual channels over one link. Each incoming flit carries a channel tag, and that tag picks the small buffer the flit lands in. Each channel then runs its own routing control. When a header reaches the head of a channel buffer, the port reads the next direction from the leading hop entry in the header payload. It offers the header to the crossbar on that direction, and the rest of the packet follows to the same output.

An output can be flagged as unusable in two ways: by the router's output status, or by the local prohibit vector. If a header points at such an output, that channel changes mode. It hands the header to a side path-rewriting unit, then holds every later flit of the packet until the unit answers. The answer either names a new output, which then receives the rest of the packet, or orders the packet dropped. A dropped packet is drained up to its tail with nothing emitted. After the tail, the channel goes back to plain routing. The upstream router is paced by credits: one credit per buffer slot per channel, returned whenever a flit leaves a buffer.

Top module: `rip_input_port`

## Requirements
- R1: A flit is written into the buffer of the channel named by its tag bit, which sits just above the payload. The two channels advance independently, so a stalled channel does not hold back the other one.
- R2: A header has kind 2'b01 in the top two flit bits. A body flit has kind 2'b10 and a tail has kind 2'b11. When a header reaches the head of an idle channel and its direction is usable, it is offered on that channel's output in the same cycle. Its direction is the low 3 payload bits, decoded as 0..4. Every later flit of the packet is offered on that same direction.
- R3: A direction counts as unusable when its bit in `dir_blocked` is set, when its bit in `local_prohibit` is set, or when its value is 5 or more. A header with an unusable direction never appears on the channel output. It is offered on the rewrite port instead, with `rw_vc` naming its channel.
- R4: Once a channel's header has been taken by the rewrite port, that channel offers no flit until a response carrying its channel number arrives.
- R5: A response with `rsp_drop` low sends every remaining flit of the packet, through the tail, to `rsp_dir`.
- R6: A response with `rsp_drop` high discards every remaining flit of the packet, through the tail. Nothing is offered, and every buffer slot is credited back.
- R7: After a tail leaves, whether forwarded or discarded, the channel treats the next flit as a new header and routes it normally.
- R8: `credit_out[v]` pulses for one cycle, one cycle after each flit leaves channel v's buffer. Credits outstanding never exceed the buffer depth.
- R9: When both channels want the rewrite port in the same cycle, channel 0 is served first.
- R10: A flit that is not a header and reaches the head of an idle channel is discarded, and its credit is returned.
- R11: After reset, no output, rewrite or credit signal is asserted, and every credit is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming flit valid |
| in_flit | input | FLIT_W | Incoming flit: kind, channel tag, payload |
| credit_out | output | NUM_VC | Per-channel credit return to upstream |
| dir_blocked | input | NUM_DIR | Output status: direction currently blocked |
| local_prohibit | input | NUM_DIR | Local prohibit flags per direction |
| out_valid | output | NUM_VC | Channel offers a flit to the crossbar |
| out_ready | input | NUM_VC | Crossbar takes the offered flit |
| out_dir | output | NUM_VC*DIR_W | Per-channel target direction |
| out_flit | output | NUM_VC*FLIT_W | Per-channel offered flit |
| rw_valid | output | 1 | Header offered to the rewrite unit |
| rw_ready | input | 1 | Rewrite unit takes the header |
| rw_vc | output | VC_W | Channel of the offered header |
| rw_flit | output | FLIT_W | Header being diverted |
| rsp_valid | input | 1 | Rewrite unit response valid |
| rsp_vc | input | VC_W | Channel the response belongs to |
| rsp_drop | input | 1 | Response orders the packet dropped |
| rsp_dir | input | DIR_W | New output for the remaining flits |

## Verification
The bench builds the block with its defaults: two channels, two-slot buffers, five directions and a 16-bit payload. With these values the flit is 19 bits wide and directions take 3 bits, so the codes 5 to 7 exist as out-of-range hop values, and the diverted-header path can be reached without any blocked flag. A two-slot buffer fills after two flits, so a blocked header plus one body flit already uses up a channel's credits. This brings credit back-pressure, the stall before a response and the drain after a drop within reach using packets of only two or three flits.

// File: rtl/rip_pkg.sv
package rip_pkg;

    typedef enum logic [1:0] {
        FK_RSVD = 2'b00,
        FK_HEAD = 2'b01,
        FK_BODY = 2'b10,
        FK_TAIL = 2'b11
    } flit_kind_e;

    typedef enum logic [2:0] {
        CH_IDLE   = 3'd0,
        CH_FWD    = 3'd1,
        CH_DIVERT = 3'd2,
        CH_WAIT   = 3'd3,
        CH_REDIR  = 3'd4,
        CH_DROP   = 3'd5
    } ch_state_e;

    function automatic logic is_head(input logic [1:0] k);
        return k == FK_HEAD;
    endfunction

    function automatic logic is_tail(input logic [1:0] k);
        return k == FK_TAIL;
    endfunction

endpackage

// File: rtl/rip_vc_fifo.sv
module rip_vc_fifo #(
    parameter int W     = 19,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         not_empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_wr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign not_empty = (cnt_q != '0);
    assign do_wr     = wr_en && (!full || rd_en);
    assign rd_data   = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) wptr_q <= bump(wptr_q);
            if (rd_en) rptr_q <= bump(rptr_q);
            cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(rd_en);
        end
    end

endmodule

// File: rtl/rip_vc_ctrl.sv
module rip_vc_ctrl
    import rip_pkg::*;
#(
    parameter int NUM_DIR = 5,
    localparam int DIR_W  = (NUM_DIR > 1) ? $clog2(NUM_DIR) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               head_valid,
    input  logic [1:0]         head_kind,
    input  logic [DIR_W-1:0]   head_hop,
    input  logic [NUM_DIR-1:0] dir_unusable,
    input  logic               out_ready,
    input  logic               rw_grant,
    input  logic               rsp_hit,
    input  logic               rsp_drop,
    input  logic [DIR_W-1:0]   rsp_dir,
    output logic               out_valid,
    output logic [DIR_W-1:0]   out_dir,
    output logic               rw_req,
    output logic               pop
);

    ch_state_e        state_q, state_d;
    logic [DIR_W-1:0] route_q, route_d;
    logic             hop_bad, discard, sent;

    always_comb begin
        hop_bad = 1'b1;
        for (int d = 0; d < NUM_DIR; d++) begin
            if (head_hop == DIR_W'(d)) hop_bad = dir_unusable[d];
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_dir   = route_q;
        rw_req    = 1'b0;
        discard   = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (head_valid) begin
                    if (!is_head(head_kind)) begin
                        discard = 1'b1;
                    end else if (!hop_bad) begin
                        out_valid = 1'b1;
                        out_dir   = head_hop;
                    end
                end
            end
            CH_FWD, CH_REDIR: out_valid = head_valid;
            CH_DIVERT:        rw_req    = head_valid;
            CH_DROP:          discard   = head_valid;
            default: ;
        endcase
    end

    assign sent = out_valid && out_ready;
    assign pop  = sent || (rw_req && rw_grant) || discard;

    always_comb begin
        state_d = state_q;
        route_d = route_q;
        unique case (state_q)
            CH_IDLE: begin
                if (head_valid && is_head(head_kind)) begin
                    if (hop_bad) begin
                        state_d = CH_DIVERT;
                    end else if (out_ready) begin
                        state_d = CH_FWD;
                        route_d = head_hop;
                    end
                end
            end
            CH_FWD, CH_REDIR: begin
                if (sent && is_tail(head_kind)) state_d = CH_IDLE;
            end
            CH_DIVERT: begin
                if (rw_req && rw_grant) state_d = CH_WAIT;
            end
            CH_WAIT: begin
                if (rsp_hit) begin
                    if (rsp_drop) begin
                        state_d = CH_DROP;
                    end else begin
                        state_d = CH_REDIR;
                        route_d = rsp_dir;
                    end
                end
            end
            CH_DROP: begin
                if (discard && is_tail(head_kind)) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            route_q <= '0;
        end else begin
            state_q <= state_d;
            route_q <= route_d;
        end
    end

endmodule

// File: rtl/rip_input_port.sv
module rip_input_port
    import rip_pkg::*;
#(
    parameter int NUM_VC    = 2,
    parameter int DEPTH     = 2,
    parameter int NUM_DIR   = 5,
    parameter int PAYLOAD_W = 16,
    localparam int DIR_W  = (NUM_DIR > 1) ? $clog2(NUM_DIR) : 1,
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int FLIT_W = 2 + VC_W + PAYLOAD_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [FLIT_W-1:0]          in_flit,
    output logic [NUM_VC-1:0]          credit_out,
    input  logic [NUM_DIR-1:0]         dir_blocked,
    input  logic [NUM_DIR-1:0]         local_prohibit,
    output logic [NUM_VC-1:0]          out_valid,
    input  logic [NUM_VC-1:0]          out_ready,
    output logic [NUM_VC*DIR_W-1:0]    out_dir,
    output logic [NUM_VC*FLIT_W-1:0]   out_flit,
    output logic                       rw_valid,
    input  logic                       rw_ready,
    output logic [VC_W-1:0]            rw_vc,
    output logic [FLIT_W-1:0]          rw_flit,
    input  logic                       rsp_valid,
    input  logic [VC_W-1:0]            rsp_vc,
    input  logic                       rsp_drop,
    input  logic [DIR_W-1:0]           rsp_dir
);

    logic [VC_W-1:0]                  in_vc;
    logic [NUM_DIR-1:0]               dir_unusable;
    logic [NUM_VC-1:0][FLIT_W-1:0]    head_flit_v;
    logic [NUM_VC-1:0][1:0]           head_kind_v;
    logic [NUM_VC-1:0][DIR_W-1:0]     out_dir_v;
    logic [NUM_VC-1:0]                head_valid_v;
    logic [NUM_VC-1:0]                pop_v;
    logic [NUM_VC-1:0]                rw_req_v;
    logic [NUM_VC-1:0]                rw_grant_v;

    assign in_vc        = in_flit[PAYLOAD_W +: VC_W];
    assign dir_unusable = dir_blocked | local_prohibit;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        rip_vc_fifo #(
            .W     (FLIT_W),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (in_valid && (in_vc == VC_W'(v))),
            .wr_data   (in_flit),
            .rd_en     (pop_v[v]),
            .rd_data   (head_flit_v[v]),
            .not_empty (head_valid_v[v])
        );

        assign head_kind_v[v] = head_flit_v[v][FLIT_W-1 -: 2];

        rip_vc_ctrl #(
            .NUM_DIR (NUM_DIR)
        ) u_ctrl (
            .clk          (clk),
            .rst          (rst),
            .head_valid   (head_valid_v[v]),
            .head_kind    (head_kind_v[v]),
            .head_hop     (head_flit_v[v][DIR_W-1:0]),
            .dir_unusable (dir_unusable),
            .out_ready    (out_ready[v]),
            .rw_grant     (rw_grant_v[v]),
            .rsp_hit      (rsp_valid && (rsp_vc == VC_W'(v))),
            .rsp_drop     (rsp_drop),
            .rsp_dir      (rsp_dir),
            .out_valid    (out_valid[v]),
            .out_dir      (out_dir_v[v]),
            .rw_req       (rw_req_v[v]),
            .pop          (pop_v[v])
        );
    end

    assign out_flit = head_flit_v;
    assign out_dir  = out_dir_v;
    assign rw_valid = |rw_req_v;

    // lowest channel index wins the rewrite port
    always_comb begin
        logic found;
        found      = 1'b0;
        rw_grant_v = '0;
        rw_vc      = '0;
        rw_flit    = head_flit_v[0];
        for (int v = 0; v < NUM_VC; v++) begin
            if (rw_req_v[v] && !found) begin
                found         = 1'b1;
                rw_vc         = VC_W'(v);
                rw_flit       = head_flit_v[v];
                rw_grant_v[v] = rw_ready;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) credit_out <= '0;
        else     credit_out <= pop_v;
    end

endmodule

// File: rtl/rip_input_port_chk.sv
module rip_input_port_chk
    import rip_pkg::*;
#(
    parameter int NUM_VC    = 2,
    parameter int DEPTH     = 2,
    parameter int NUM_DIR   = 5,
    parameter int DIR_W     = 3,
    parameter int VC_W      = 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [VC_W-1:0]          in_vc,
    input logic [NUM_VC-1:0]        pop_v,
    input logic [NUM_VC-1:0]        credit_out,
    input logic [NUM_VC-1:0]        out_valid,
    input logic [NUM_VC-1:0][1:0]   head_kind_v,
    input logic [NUM_VC*DIR_W-1:0]  out_dir,
    input logic [NUM_DIR-1:0]       dir_blocked,
    input logic [NUM_DIR-1:0]       local_prohibit,
    input logic [NUM_VC-1:0]        rw_req_v,
    input logic                     rw_valid,
    input logic                     rw_ready,
    input logic [VC_W-1:0]          rw_vc,
    input logic [1:0]               rw_kind,
    input logic                     rsp_valid,
    input logic [VC_W-1:0]          rsp_vc
);

    localparam int CW = $clog2(DEPTH + 2) + 1;

    function automatic logic dir_usable(input logic [DIR_W-1:0] d,
                                        input logic [NUM_DIR-1:0] bad);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < NUM_DIR; i++) begin
            if (d == DIR_W'(i)) ok = !bad[i];
        end
        return ok;
    endfunction

    p_rw_header_r3: assert property (@(posedge clk) disable iff (rst)
        rw_valid |-> is_head(rw_kind));

    p_rw_priority_r9: assert property (@(posedge clk) disable iff (rst)
        rw_req_v[0] |-> (rw_valid && rw_vc == '0));

    for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
        logic [CW-1:0] occ_q, owed_q;
        logic          pend_q;
        logic          wr;

        assign wr = in_valid && (in_vc == VC_W'(v));

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q  <= '0;
                owed_q <= '0;
                pend_q <= 1'b0;
            end else begin
                occ_q  <= occ_q + CW'(wr) - CW'(pop_v[v]);
                owed_q <= owed_q + CW'(wr) - CW'(credit_out[v]);
                if (rsp_valid && rsp_vc == VC_W'(v))
                    pend_q <= 1'b0;
                else if (rw_valid && rw_ready && rw_vc == VC_W'(v))
                    pend_q <= 1'b1;
            end
        end

        p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
            wr |-> (occ_q < CW'(DEPTH) || pop_v[v]));

        p_credit_bound_r8: assert property (@(posedge clk) disable iff (rst)
            owed_q <= CW'(DEPTH));

        p_stall_r4: assert property (@(posedge clk) disable iff (rst)
            pend_q |-> !out_valid[v]);

        p_header_usable_r3: assert property (@(posedge clk) disable iff (rst)
            (out_valid[v] && is_head(head_kind_v[v])) |->
                dir_usable(out_dir[v*DIR_W +: DIR_W], dir_blocked | local_prohibit));
    end

endmodule

bind rip_input_port rip_input_port_chk #(
    .NUM_VC  (NUM_VC),
    .DEPTH   (DEPTH),
    .NUM_DIR (NUM_DIR),
    .DIR_W   (DIR_W),
    .VC_W    (VC_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_vc          (in_vc),
    .pop_v          (pop_v),
    .credit_out     (credit_out),
    .out_valid      (out_valid),
    .head_kind_v    (head_kind_v),
    .out_dir        (out_dir),
    .dir_blocked    (dir_blocked),
    .local_prohibit (local_prohibit),
    .rw_req_v       (rw_req_v),
    .rw_valid       (rw_valid),
    .rw_ready       (rw_ready),
    .rw_vc          (rw_vc),
    .rw_kind        (rw_flit[FLIT_W-1 -: 2]),
    .rsp_valid      (rsp_valid),
    .rsp_vc         (rsp_vc)
);

// File: tb/tb_rip_input_port.sv
`timescale 1ns/1ps
module tb_rip_input_port;

    localparam int NV = 2, DP = 2, ND = 5, PW = 16;
    localparam int DW = 3, FW = 19;
    localparam logic [1:0] K_HEAD = 2'b01, K_BODY = 2'b10, K_TAIL = 2'b11;

    logic          clk = 0, rst = 1;
    logic          in_valid = 0;
    logic [FW-1:0] in_flit = '0;
    logic [NV-1:0] credit_out;
    logic [ND-1:0] dir_blocked = '0, local_prohibit = '0;
    logic [NV-1:0] out_valid, out_ready = '1;
    logic [NV*DW-1:0] out_dir;
    logic [NV*FW-1:0] out_flit;
    logic          rw_valid, rw_ready = 1;
    logic          rw_vc;
    logic [FW-1:0] rw_flit;
    logic          rsp_valid = 0, rsp_vc = 0, rsp_drop = 0;
    logic [DW-1:0] rsp_dir = '0;

    always #10 clk = ~clk;

    rip_input_port #(.NUM_VC(NV), .DEPTH(DP), .NUM_DIR(ND), .PAYLOAD_W(PW)) dut (.*);

    int checks = 0, errors = 0;
    int cred [NV];
    int cpulse [NV];
    logic [FW-1:0] olog [NV][16];
    logic [DW-1:0] odir [NV][16];
    int ocnt [NV];
    logic [FW-1:0] rlog [16];
    logic          rvc [16];
    int rcnt = 0;
    bit done = 0;

    // monitor, mid low phase
    always begin
        @(negedge clk);
        #5;
        if (!rst) begin
            for (int v = 0; v < NV; v++) begin
                if (credit_out[v]) begin cred[v]++; cpulse[v]++; end
                if (out_valid[v] && out_ready[v] && ocnt[v] < 16) begin
                    olog[v][ocnt[v]] = out_flit[v*FW +: FW];
                    odir[v][ocnt[v]] = out_dir[v*DW +: DW];
                    ocnt[v]++;
                end
            end
            if (rw_valid && rw_ready && rcnt < 16) begin
                rlog[rcnt] = rw_flit; rvc[rcnt] = rw_vc; rcnt++;
            end
        end
    end

    function automatic logic [FW-1:0] mk(logic [1:0] k, logic v, logic [15:0] p);
        return {k, v, p};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int v = 0; v < NV; v++) begin ocnt[v] = 0; cpulse[v] = 0; end
        rcnt = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic v, logic [1:0] k, logic [15:0] p);
        @(negedge clk);
        while (cred[v] == 0) @(negedge clk);
        in_valid = 1; in_flit = mk(k, v, p); cred[v]--;
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic respond(logic v, logic [2:0] d, logic drop);
        @(negedge clk);
        rsp_valid = 1; rsp_vc = v; rsp_dir = d; rsp_drop = drop;
        @(negedge clk);
        rsp_valid = 0; rsp_drop = 0;
    endtask

    task automatic t_reset();
        chk("R11 out_valid", int'(out_valid), 0);
        chk("R11 rw_valid", int'(rw_valid), 0);
        chk("R11 credit_out", int'(credit_out), 0);
    endtask

    task automatic t_normal();
        clear_logs();
        send(0, K_HEAD, 16'h1232);
        send(0, K_BODY, 16'hBEEF);
        send(0, K_TAIL, 16'h7777);
        idle(5);
        chk("R2 count", ocnt[0], 3);
        chk("R2 head flit", int'(olog[0][0]), int'(mk(K_HEAD, 0, 16'h1232)));
        chk("R2 body dir", int'(odir[0][1]), 2);
        chk("R2 tail flit", int'(olog[0][2]), int'(mk(K_TAIL, 0, 16'h7777)));
        chk("R8 credit pulses", cpulse[0], 3);
    endtask

    task automatic t_independent();
        clear_logs();
        out_ready[0] = 0;
        send(0, K_HEAD, 16'h0004);
        send(0, K_BODY, 16'h1111);
        send(1, K_HEAD, 16'h0001);
        send(1, K_TAIL, 16'h2222);
        idle(5);
        chk("R1 vc1 passes", ocnt[1], 2);
        chk("R1 vc1 dir", int'(odir[1][1]), 1);
        chk("R1 vc0 held", ocnt[0], 0);
        chk("R2 held dir", int'(out_dir[DW-1:0]), 4);
        chk("R8 vc0 no credit", cred[0], 0);
        out_ready[0] = 1;
        send(0, K_TAIL, 16'h3333);
        idle(5);
        chk("R1 vc0 drained", ocnt[0], 3);
        chk("R2 vc0 tail dir", int'(odir[0][2]), 4);
    endtask

    task automatic t_blocked_redirect();
        clear_logs();
        dir_blocked = 5'b01000;
        send(0, K_HEAD, 16'h00A3);
        send(0, K_BODY, 16'h4444);
        send(0, K_TAIL, 16'h5555);
        idle(6);
        chk("R3 diverted", rcnt, 1);
        chk("R3 rw flit", int'(rlog[0]), int'(mk(K_HEAD, 0, 16'h00A3)));
        chk("R3 rw vc", int'(rvc[0]), 0);
        chk("R4 stalled", ocnt[0], 0);
        respond(0, 3'd1, 0);
        idle(5);
        chk("R5 count", ocnt[0], 2);
        chk("R5 body dir", int'(odir[0][0]), 1);
        chk("R5 tail", int'(olog[0][1]), int'(mk(K_TAIL, 0, 16'h5555)));
        dir_blocked = '0;
        clear_logs();
        send(0, K_HEAD, 16'h0003);
        send(0, K_TAIL, 16'h0000);
        idle(5);
        chk("R7 normal again", ocnt[0], 2);
        chk("R7 dir", int'(odir[0][0]), 3);
        chk("R7 no divert", rcnt, 0);
    endtask

    task automatic t_prohibit_drop();
        clear_logs();
        local_prohibit = 5'b00100;
        send(1, K_HEAD, 16'h0002);
        send(1, K_BODY, 16'h6666);
        send(1, K_TAIL, 16'h6767);
        idle(6);
        chk("R3 prohibit divert", rcnt, 1);
        chk("R3 prohibit vc", int'(rvc[0]), 1);
        respond(1, 3'd0, 1);
        idle(6);
        chk("R6 nothing out", ocnt[1], 0);
        chk("R6 credits back", cred[1], DP);
        local_prohibit = '0;
        send(1, K_HEAD, 16'h0002);
        send(1, K_TAIL, 16'h0009);
        idle(5);
        chk("R7 after drop", ocnt[1], 2);
        chk("R7 after drop dir", int'(odir[1][1]), 2);
    endtask

    task automatic t_out_of_range();
        clear_logs();
        send(0, K_HEAD, 16'h0A06);
        send(0, K_TAIL, 16'h0BBB);
        idle(6);
        chk("R3 range divert", rcnt, 1);
        chk("R3 range no out", ocnt[0], 0);
        respond(0, 3'd0, 0);
        idle(4);
        chk("R5 range tail dir", int'(odir[0][0]), 0);
    endtask

    task automatic t_priority();
        clear_logs();
        rw_ready = 0;
        dir_blocked = 5'b00001;
        send(1, K_HEAD, 16'h0010);
        send(0, K_HEAD, 16'h0020);
        idle(3);
        chk("R9 both waiting", int'(rw_valid), 1);
        chk("R9 vc0 first", int'(rw_vc), 0);
        rw_ready = 1;
        idle(4);
        chk("R9 both served", rcnt, 2);
        chk("R9 order vc0", int'(rvc[0]), 0);
        chk("R9 order vc1", int'(rvc[1]), 1);
        dir_blocked = '0;
        respond(1, 3'd4, 0);
        respond(0, 3'd2, 0);
        send(0, K_TAIL, 16'h00C0);
        send(1, K_TAIL, 16'h00C1);
        idle(5);
        chk("R5 vc0 dir", int'(odir[0][0]), 2);
        chk("R5 vc1 dir", int'(odir[1][0]), 4);
    endtask

    task automatic t_stray();
        clear_logs();
        send(0, K_BODY, 16'hDEAD);
        idle(4);
        chk("R10 no out", ocnt[0], 0);
        chk("R10 credit back", cred[0], DP);
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin cred[v] = DP; ocnt[v] = 0; cpulse[v] = 0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        t_normal();
        t_independent();
        t_blocked_redirect();
        t_prohibit_drop();
        t_out_of_range();
        t_priority();
        t_stray();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule